// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a run-time configurable two-level AND/OR array. A bank of product terms is evaluated in parallel from a common data input vector. Each term picks, for every input bit, whether that bit takes part in true form, in complemented form, or not at all. A second plane then ORs any subset of those terms into each output. Because one term can feed any number of outputs, several related sum-of-products functions can share their common terms.

The data path is purely combinational. The personality is held in flops and written synchronously, one term row per write. A row carries both the literal codes of that term and the set of outputs the term drives. Reset clears every row, so the array starts with no output connected. There is no state machine. The only sequential behaviour is the row storage, which holds its value except on the clock edge that samples a write addressed to that row.

Top module: `pla_core`

## Requirements
- R1: A literal code of 2'b01 in bits [2i+1:2i] of a term row makes that term require data input bit i to be 1.
- R2: A literal code of 2'b10 in bits [2i+1:2i] makes the term require data input bit i to be 0.
- R3: A literal code of 2'b00 leaves input bit i out of the term, so a term whose literals are all 2'b00 is always 1.
- R4: A literal code of 2'b11 in any position forces that term to 0 for every input value.
- R5: Output bit o is the OR of every term whose link bit o is set, and it is 0 when no term links to it.
- R6: A single term row with several link bits set drives all of those outputs at once.
- R7: After reset every literal code is 2'b00 and every link bit is 0, so all outputs read 0 for any data input.
- R8: A write with `cfg_we` high replaces the literals and links of row `cfg_row` at the next rising clock edge. It has no effect before that edge, and it leaves every other row unchanged.
- R9: With three inputs A = din[2], B = din[1] and C = din[0], and the five terms AB, B'C, AC', B'C' and A loaded, the outputs give dout[0] = A + B'C', dout[1] = AC' + AB, dout[2] = B'C' + AB and dout[3] = B'C + A.
- R10: `dout` follows `din` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the personality storage |
| rst | input | 1 | Synchronous active-high reset; clears the personality |
| cfg_we | input | 1 | Row write enable |
| cfg_row | input | TERM_AW | Index of the term row being written |
| cfg_lits | input | 2*N_IN | Literal codes for the row, two bits per input |
| cfg_links | input | N_OUT | Output link mask for the row |
| din | input | N_IN | Data inputs |
| dout | output | N_OUT | Sum-of-products outputs |

## Verification
A corrupted personality row can hide until the input pattern that depends on the damaged literal or link is applied. For that reason, every check sweeps all data input values after each configuration change. A write that reaches the wrong row, or that lands one edge early or late, shows up as a wrong `dout` value in the cycle after the intended edge. A fault in a literal decode affects only the input half-space that the literal selects. The directed sweeps per code value catch it within one sweep.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        LIT_SKIP  = 2'b00,
        LIT_POS   = 2'b01,
        LIT_NEG   = 2'b10,
        LIT_NEVER = 2'b11
    } lit_e;

endpackage

// File: rtl/pla_row_store.sv
module pla_row_store #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4,
    parameter int AW     = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [AW-1:0]                      cfg_row,
    input  logic [2*N_IN-1:0]                  cfg_lits,
    input  logic [N_OUT-1:0]                   cfg_links,
    output logic [N_TERM-1:0][2*N_IN-1:0]      lits_q,
    output logic [N_TERM-1:0][N_OUT-1:0]       links_q
);

    genvar r;
    generate
        for (r = 0; r < N_TERM; r++) begin : g_row
            localparam logic [AW-1:0] ROW_ID = AW'(r);
            logic hit_w;

            assign hit_w = cfg_we && (cfg_row == ROW_ID);

            always_ff @(posedge clk) begin
                if (rst) begin
                    lits_q[r]  <= '0;
                    links_q[r] <= '0;
                end else if (hit_w) begin
                    lits_q[r]  <= cfg_lits;
                    links_q[r] <= cfg_links;
                end
            end

            // R8
            row_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !(cfg_we && cfg_row == ROW_ID) |=> ($stable(lits_q[r]) && $stable(links_q[r])));

            // R8
            row_load_chk: assert property (@(posedge clk) disable iff (rst)
                (cfg_we && cfg_row == ROW_ID) |=> (lits_q[r] == $past(cfg_lits)));
        end
    endgenerate

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_IN-1:0]               din,
    input  logic [N_TERM-1:0][2*N_IN-1:0] lits_q,
    output logic [N_TERM-1:0]             term_on
);

    genvar t;
    generate
        for (t = 0; t < N_TERM; t++) begin : g_term
            logic [N_IN-1:0] lit_ok;
            logic            has_never;

            always_comb begin
                has_never = 1'b0;
                for (int i = 0; i < N_IN; i++) begin
                    unique case (lit_e'(lits_q[t][2*i +: 2]))
                        LIT_SKIP:  lit_ok[i] = 1'b1;
                        LIT_POS:   lit_ok[i] = din[i];
                        LIT_NEG:   lit_ok[i] = ~din[i];
                        LIT_NEVER: begin
                            lit_ok[i] = 1'b0;
                            has_never = 1'b1;
                        end
                    endcase
                end
            end

            assign term_on[t] = &lit_ok;

            // R4
            never_term_chk: assert property (@(posedge clk) disable iff (rst)
                has_never |-> !term_on[t]);

            // R3
            open_term_chk: assert property (@(posedge clk) disable iff (rst)
                (lits_q[t] == '0) |-> term_on[t]);
        end
    endgenerate

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 8,
    parameter int N_OUT  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_TERM-1:0]           term_on,
    input  logic [N_TERM-1:0][N_OUT-1:0] links_q,
    output logic [N_OUT-1:0]            dout
);

    genvar o;
    generate
        for (o = 0; o < N_OUT; o++) begin : g_out
            logic [N_TERM-1:0] column;

            always_comb begin
                for (int t = 0; t < N_TERM; t++) begin
                    column[t] = links_q[t][o];
                end
            end

            assign dout[o] = |(column & term_on);

            // R5
            unlinked_out_chk: assert property (@(posedge clk) disable iff (rst)
                (column == '0) |-> !dout[o]);
        end
    endgenerate

endmodule

// File: rtl/pla_core.sv
module pla_core #(
    parameter int N_IN    = 4,
    parameter int N_TERM  = 8,
    parameter int N_OUT   = 4,
    parameter int TERM_AW = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [TERM_AW-1:0]   cfg_row,
    input  logic [2*N_IN-1:0]    cfg_lits,
    input  logic [N_OUT-1:0]     cfg_links,
    input  logic [N_IN-1:0]      din,
    output logic [N_OUT-1:0]     dout
);

    logic [N_TERM-1:0][2*N_IN-1:0] lits_q;
    logic [N_TERM-1:0][N_OUT-1:0]  links_q;
    logic [N_TERM-1:0]             term_on;

    pla_row_store #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(TERM_AW)
    ) u_store (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_lits(cfg_lits), .cfg_links(cfg_links),
        .lits_q(lits_q), .links_q(links_q)
    );

    pla_and_plane #(
        .N_IN(N_IN), .N_TERM(N_TERM)
    ) u_and (
        .clk(clk), .rst(rst), .din(din), .lits_q(lits_q), .term_on(term_on)
    );

    pla_or_plane #(
        .N_TERM(N_TERM), .N_OUT(N_OUT)
    ) u_or (
        .clk(clk), .rst(rst), .term_on(term_on), .links_q(links_q), .dout(dout)
    );

    // R7
    cleared_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dout == '0));

    // R6
    shared_term_chk: assert property (@(posedge clk) disable iff (rst)
        ((term_on & {N_TERM{1'b1}}) != '0 && links_q[0] != '0 && term_on[0])
            |-> ((dout & links_q[0]) == links_q[0]));

endmodule

// File: tb/test_pla_core.sv
module test_pla_core;

    localparam int N_IN   = 4;
    localparam int N_TERM = 8;
    localparam int N_OUT  = 4;
    localparam int AW     = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_row = '0;
    logic [2*N_IN-1:0] cfg_lits = '0;
    logic [N_OUT-1:0]  cfg_links = '0;
    logic [N_IN-1:0]   din = '0;
    logic [N_OUT-1:0]  dout;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [2*N_IN-1:0] m_lits  [N_TERM];
    logic [N_OUT-1:0]  m_links [N_TERM];

    always #10 clk = ~clk;

    pla_core #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) i_pla_core (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_lits(cfg_lits), .cfg_links(cfg_links), .din(din), .dout(dout)
    );

    function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] x);
        logic [N_OUT-1:0] acc = '0;
        for (int t = 0; t < N_TERM; t++) begin
            logic on = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                case (m_lits[t][2*i +: 2])
                    2'b01: on = on & x[i];
                    2'b10: on = on & ~x[i];
                    2'b11: on = 1'b0;
                    default: ;
                endcase
            end
            if (on) acc = acc | m_links[t];
        end
        return acc;
    endfunction

    function automatic logic [2*N_IN-1:0] lits3(input logic [1:0] a, input logic [1:0] b,
                                                input logic [1:0] c);
        return {2'b00, a, b, c};
    endfunction

    task automatic check(input string req, input logic [N_OUT-1:0] exp);
        n_chk++;
        if (dout !== exp) begin
            n_bad++;
            $display("FAIL %s din=%b actual=%b expected=%b", req, din, dout, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < (1 << N_IN); v++) begin
            din = N_IN'(v);
            #1;
            check(req, model(din));
        end
    endtask

    task automatic wr(input int row, input logic [2*N_IN-1:0] l, input logic [N_OUT-1:0] k);
        @(negedge clk);
        cfg_we = 1'b1; cfg_row = AW'(row); cfg_lits = l; cfg_links = k;
        @(posedge clk);
        m_lits[row] = l; m_links[row] = k;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_model();
        for (int t = 0; t < N_TERM; t++) begin
            m_lits[t] = '0; m_links[t] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        clear_model();
    endtask

    initial begin
        void'($urandom(32'd1234));
        clear_model();
        do_reset();

        // R7: cleared personality
        for (int v = 0; v < (1 << N_IN); v++) begin
            din = N_IN'(v); #1; check("R7", '0);
        end

        // R9 + R6: reference personality, A=din[2] B=din[1] C=din[0]
        wr(0, lits3(2'b01, 2'b01, 2'b00), 4'b0110);
        wr(1, lits3(2'b00, 2'b10, 2'b01), 4'b1000);
        wr(2, lits3(2'b01, 2'b00, 2'b10), 4'b0010);
        wr(3, lits3(2'b00, 2'b10, 2'b10), 4'b0101);
        wr(4, lits3(2'b01, 2'b00, 2'b00), 4'b1001);
        for (int v = 0; v < 16; v++) begin
            logic a, b, c;
            logic [3:0] e;
            din = 4'(v); #1;
            a = din[2]; b = din[1]; c = din[0];
            e[0] = a | (~b & ~c);
            e[1] = (a & ~c) | (a & b);
            e[2] = (~b & ~c) | (a & b);
            e[3] = (~b & c) | a;
            check("R9_R6", e);
        end

        // R1, R2, R3, R4 directed literal cases
        do_reset();
        wr(0, 8'b00_00_00_01, 4'b0001); sweep("R1");
        wr(0, 8'b10_00_00_00, 4'b0001); sweep("R2");
        wr(1, 8'b00_00_00_00, 4'b0010); sweep("R3");
        wr(1, 8'b00_11_00_00, 4'b0010); sweep("R4");
        wr(2, 8'b00_00_00_00, 4'b0000); sweep("R5");

        // R8: no effect before the edge, other rows untouched
        @(negedge clk);
        din = '0;
        cfg_we = 1'b1; cfg_row = 3'd5; cfg_lits = '0; cfg_links = 4'b1000;
        #1; check("R8", model(din));
        @(posedge clk);
        m_lits[5] = '0; m_links[5] = 4'b1000;
        @(negedge clk);
        cfg_we = 1'b0;
        sweep("R8");

        // R10: output follows input with no clock edge
        @(negedge clk);
        din = 4'b0001; #1; check("R10", model(din));
        din = 4'b0000; #1; check("R10", model(din));

        // random personality writes
        for (int it = 0; it < 150; it++) begin
            wr($urandom_range(N_TERM-1), 8'($urandom), 4'($urandom));
            for (int k = 0; k < 4; k++) begin
                din = 4'($urandom); #1; check("R5_R6", model(din));
            end
        end

        // R7 again after a dense personality
        do_reset();
        sweep("R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule